// File: doc/BRIEF.md
# SPI Target Serial Front End with Hold

This block is the bit-level front end of a serial memory target on an SPI bus. It runs entirely in the system clock domain: the serial clock, chip select, hold and data-in pins are brought through synchronisers, and their edges are found by comparing successive synchronised samples. The system clock must run at least four times as fast as the serial clock.

While the target is selected, the block gathers data-in bits into bytes, most significant bit first, and reports each finished byte with its position in the transfer. In the other direction, it takes bytes from the instruction layer above, shifts them out most significant bit first, and drives an output-enable with them. The hold pin pauses the transfer without deselecting the target. When chip select is released, the block reports whether the transfer held a whole number of bytes. The command layer above uses that flag to reject writes that were cut short.

Top module: `spi_target_frontend`

## Requirements
- R1: Each data-in bit is taken on a rising serial clock edge, most significant bit first. After every eighth rising edge of a transfer, `rx_valid_o` pulses for exactly one system clock with the assembled byte on `rx_data_o`.
- R2: `rx_index_o` is 0 for the first byte after chip select falls and grows by one for each later byte of the same transfer.
- R3: The block works with the serial clock idling low and with it idling high. The first rising edge after chip select falls carries bit 7 of byte 0 in both cases.
- R4: `miso_o` presents `tx_data_i` most significant bit first. Byte 0 is loaded when the transfer starts. The next byte is loaded, with a one-cycle `tx_load_o` pulse, on the first falling edge after a byte's eighth rising edge. `miso_o` changes only after a falling serial clock edge.
- R5: When chip select rises at the end of a started transfer, `frame_end_o` pulses for one cycle. At the same time `frame_aligned_o` is 1 exactly when the count of rising edges in that transfer is a multiple of 8.
- R6: `miso_oe_o` is 0, and `miso_o` is 0, while chip select is high and while a hold is in force.
- R7: A hold begins when HOLD_n is low while the serial clock is low, and it ends when HOLD_n is high while the serial clock is low. A change of HOLD_n while the serial clock is high takes effect only after the serial clock next falls. `hold_active_o` shows the hold.
- R8: During a hold, serial clock edges and data-in are ignored. No byte is reported, and the bit count and both shift registers keep their values.
- R9: Releasing chip select during a hold ends the transfer, reports `frame_end_o`, and clears the hold. A chip select falling edge while HOLD_n is low starts no transfer: no bytes, no output enable and no `frame_end_o` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| mosi_i | input | 1 | Serial data in |
| holdn_i | input | 1 | Hold request, active low |
| tx_data_i | input | DATA_W | Byte to shift out, sampled when a load occurs |
| tx_load_o | output | 1 | Pulse: `tx_data_i` was just loaded |
| miso_o | output | 1 | Serial data out (0 when not enabled) |
| miso_oe_o | output | 1 | Output enable for the data-out pad |
| rx_valid_o | output | 1 | Pulse: a received byte is on `rx_data_o` |
| rx_data_o | output | DATA_W | Received byte |
| rx_index_o | output | IDX_W | Byte position within the transfer |
| frame_end_o | output | 1 | Pulse: transfer ended by chip select rising |
| frame_aligned_o | output | 1 | Edge count of the ended transfer was a multiple of 8 |
| hold_active_o | output | 1 | A hold is in force |

## Verification
The bound checker watches, on every cycle, the properties that are local in time. These are: the output enable is off whenever select is high or a hold is in force; a change on data-out is always preceded by a detected falling edge; the hold state moves only while the synchronised clock is low; no byte is reported during a hold; and the status pulses last one cycle. The bench scenarios show the properties that depend on a whole transfer. These are the byte values and indices in both clock idle levels, the outgoing bit order and byte reloads, the alignment flag for whole and partial transfers, the deferred start and end of a hold, and the lock-out after select is released during a hold.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [1:0] {
        SESS_IDLE   = 2'd0,
        SESS_LIVE   = 2'd1,
        SESS_PAUSED = 2'd2
    } sess_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edges_t;

    localparam int unsigned SYNC_MIN_STAGES = 2;

    function automatic edges_t find_edges(input logic now_lvl, input logic prev_lvl);
        edges_t e;
        e.rise = now_lvl & ~prev_lvl;
        e.fall = ~now_lvl & prev_lvl;
        return e;
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_session.sv
module spi_fe_session
    import spi_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sck_lvl,
    input  logic  holdn_lvl,
    input  logic  cs_fall,
    input  logic  cs_rise,
    input  logic  bit_aligned,
    output sess_e state_o,
    output logic  start_o,
    output logic  frame_end_o,
    output logic  frame_aligned_o
);
    sess_e state_q;
    sess_e state_n;

    assign start_o = cs_fall & holdn_lvl;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SESS_IDLE: begin
                if (start_o) state_n = SESS_LIVE;
            end
            SESS_LIVE: begin
                if (cs_rise) state_n = SESS_IDLE;
                else if (!sck_lvl && !holdn_lvl) state_n = SESS_PAUSED;
            end
            SESS_PAUSED: begin
                if (cs_rise) state_n = SESS_IDLE;
                else if (!sck_lvl && holdn_lvl) state_n = SESS_LIVE;
            end
            default: state_n = SESS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q         <= SESS_IDLE;
            frame_end_o     <= 1'b0;
            frame_aligned_o <= 1'b0;
        end else begin
            state_q     <= state_n;
            frame_end_o <= 1'b0;
            if (cs_rise && state_q != SESS_IDLE) begin
                frame_end_o     <= 1'b1;
                frame_aligned_o <= bit_aligned;
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sample_i,
    input  logic              mosi_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [IDX_W-1:0]  index_o,
    output logic              aligned_o
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] sr_next;
    logic [BIT_W-1:0]  bitpos_q;
    logic [IDX_W-1:0]  count_q;

    assign sr_next = {sr_q[DATA_W-2:0], mosi_i};

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            sr_q     <= '0;
            bitpos_q <= '0;
            count_q  <= '0;
            valid_o  <= 1'b0;
            if (rst) begin
                data_o  <= '0;
                index_o <= '0;
            end
        end else begin
            valid_o <= 1'b0;
            if (sample_i) begin
                sr_q <= sr_next;
                if (bitpos_q == LAST_BIT) begin
                    bitpos_q <= '0;
                    valid_o  <= 1'b1;
                    data_o   <= sr_next;
                    index_o  <= count_q;
                    count_q  <= count_q + 1'b1;
                end else begin
                    bitpos_q <= bitpos_q + 1'b1;
                end
            end
        end
    end

    assign aligned_o = (bitpos_q == '0);
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sample_i,
    input  logic              shift_i,
    input  logic              boundary_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o,
    output logic              load_o
);
    logic [DATA_W-1:0] sr_q;
    logic              consumed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q       <= '1;
            consumed_q <= 1'b0;
            load_o     <= 1'b0;
        end else begin
            load_o <= 1'b0;
            if (start_i) begin
                sr_q       <= data_i;
                consumed_q <= 1'b0;
                load_o     <= 1'b1;
            end else begin
                if (sample_i) consumed_q <= 1'b1;
                if (shift_i && consumed_q) begin
                    consumed_q <= 1'b0;
                    if (boundary_i) begin
                        sr_q   <= data_i;
                        load_o <= 1'b1;
                    end else begin
                        sr_q <= {sr_q[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign bit_o = sr_q[DATA_W-1];
endmodule

// File: rtl/spi_target_frontend.sv
module spi_target_frontend
    import spi_fe_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned IDX_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    input  logic              holdn_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_load_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic [IDX_W-1:0]  rx_index_o,
    output logic              frame_end_o,
    output logic              frame_aligned_o,
    output logic              hold_active_o
);
    localparam int unsigned NSIG  = 4;
    localparam int unsigned DEPTH = (SYNC_STAGES < SYNC_MIN_STAGES) ? SYNC_MIN_STAGES : SYNC_STAGES;
    // bit 0 sck, bit 1 chip select, bit 2 hold, bit 3 data in
    localparam logic [NSIG-1:0] IDLE_LVL = 4'b0110;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] lvl;

    assign raw = {mosi_i, holdn_i, csn_i, sck_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        spi_fe_sync #(
            .STAGES  (DEPTH),
            .RST_VAL (IDLE_LVL[g])
        ) sync_i (
            .clk (clk),
            .rst (rst),
            .d_i (raw[g]),
            .q_o (lvl[g])
        );
    end

    logic sck_s, csn_s, holdn_s, mosi_s;
    assign sck_s   = lvl[0];
    assign csn_s   = lvl[1];
    assign holdn_s = lvl[2];
    assign mosi_s  = lvl[3];

    logic sck_d, csn_d;
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= IDLE_LVL[0];
            csn_d <= IDLE_LVL[1];
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    edges_t sck_e, csn_e;
    assign sck_e = find_edges(sck_s, sck_d);
    assign csn_e = find_edges(csn_s, csn_d);

    sess_e sess_state;
    logic  sess_start;
    logic  bit_aligned;
    logic  live;
    logic  rx_sample;
    logic  tx_shift_ev;
    logic  tx_bit;

    spi_fe_session session_i (
        .clk             (clk),
        .rst             (rst),
        .sck_lvl         (sck_s),
        .holdn_lvl       (holdn_s),
        .cs_fall         (csn_e.fall),
        .cs_rise         (csn_e.rise),
        .bit_aligned     (bit_aligned),
        .state_o         (sess_state),
        .start_o         (sess_start),
        .frame_end_o     (frame_end_o),
        .frame_aligned_o (frame_aligned_o)
    );

    assign live        = (sess_state == SESS_LIVE);
    assign rx_sample   = live & sck_e.rise;
    assign tx_shift_ev = live & sck_e.fall;

    spi_fe_rx #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) rx_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (sess_start),
        .sample_i  (rx_sample),
        .mosi_i    (mosi_s),
        .valid_o   (rx_valid_o),
        .data_o    (rx_data_o),
        .index_o   (rx_index_o),
        .aligned_o (bit_aligned)
    );

    spi_fe_tx #(
        .DATA_W (DATA_W)
    ) tx_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (sess_start),
        .sample_i   (rx_sample),
        .shift_i    (tx_shift_ev),
        .boundary_i (bit_aligned),
        .data_i     (tx_data_i),
        .bit_o      (tx_bit),
        .load_o     (tx_load_o)
    );

    assign miso_oe_o     = live & ~csn_s;
    assign miso_o        = miso_oe_o & tx_bit;
    assign hold_active_o = (sess_state == SESS_PAUSED);
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker
    import spi_fe_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  sck_lvl,
    input logic  csn_lvl,
    input sess_e state,
    input logic  shift_ev,
    input logic  miso_o,
    input logic  miso_oe_o,
    input logic  rx_valid_o,
    input logic  frame_end_o,
    input logic  hold_active_o
);
    assert_rx_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    assert_miso_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (miso_oe_o && $past(miso_oe_o) && (miso_o != $past(miso_o))) |-> $past(shift_ev));

    assert_frame_end_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |=> !frame_end_o);

    assert_oe_off_deselected_R6: assert property (@(posedge clk) disable iff (rst)
        csn_lvl |-> !miso_oe_o);

    assert_oe_off_held_R6: assert property (@(posedge clk) disable iff (rst)
        hold_active_o |-> (!miso_oe_o && !miso_o));

    assert_hold_enter_sck_low_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == SESS_LIVE && state == SESS_PAUSED) |-> !$past(sck_lvl));

    assert_hold_exit_sck_low_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == SESS_PAUSED && state == SESS_LIVE) |-> !$past(sck_lvl));

    assert_no_byte_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
        hold_active_o |-> !rx_valid_o);
endmodule

bind spi_target_frontend spi_fe_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .sck_lvl       (sck_s),
    .csn_lvl       (csn_s),
    .state         (sess_state),
    .shift_ev      (tx_shift_ev),
    .miso_o        (miso_o),
    .miso_oe_o     (miso_oe_o),
    .rx_valid_o    (rx_valid_o),
    .frame_end_o   (frame_end_o),
    .hold_active_o (hold_active_o)
);

// File: tb/spi_target_frontend_tb.sv
`timescale 1ns/1ps
module spi_target_frontend_tb_top;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0, csn = 1'b1, mosi = 1'b0, holdn = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_load, miso, miso_oe, rx_valid, frame_end, frame_aligned, hold_active;
    logic [7:0]  rx_data;
    logic [15:0] rx_index;

    int n_chk = 0;
    int n_fail = 0;
    int load_cnt = 0;
    int cyc = 0;
    logic [23:0] rxq[$];
    logic        fq[$];

    always #2 clk = ~clk;

    spi_target_frontend dut_i (
        .clk (clk), .rst (rst), .sck_i (sck), .csn_i (csn), .mosi_i (mosi),
        .holdn_i (holdn), .tx_data_i (tx_data), .tx_load_o (tx_load),
        .miso_o (miso), .miso_oe_o (miso_oe), .rx_valid_o (rx_valid),
        .rx_data_o (rx_data), .rx_index_o (rx_index), .frame_end_o (frame_end),
        .frame_aligned_o (frame_aligned), .hold_active_o (hold_active)
    );

    function automatic logic [7:0] txpat(input int k);
        return 8'hA5 ^ 8'(k * 37);
    endfunction

    function automatic logic [7:0] mopat(input int k);
        return 8'h3C + 8'(k * 53);
    endfunction

    assign tx_data = txpat(load_cnt);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_up();
        end
    end

    // reference comparison on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_load) load_cnt++;
            if (rx_valid) begin
                if (rxq.size() == 0) begin
                    chk(1'b0, "R8/R9", "unexpected byte", int'(rx_data), 0);
                end else begin
                    logic [23:0] e;
                    e = rxq.pop_front();
                    chk(rx_data == e[23:16], "R1", "rx byte", int'(rx_data), int'(e[23:16]));
                    chk(rx_index == e[15:0], "R2", "rx index", int'(rx_index), int'(e[15:0]));
                end
            end
            if (frame_end) begin
                if (fq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected frame end", 1, 0);
                end else begin
                    logic ea;
                    ea = fq.pop_front();
                    chk(frame_aligned == ea, "R5", "aligned flag", int'(frame_aligned), int'(ea));
                end
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic junk_pulses(input bit end_high);
        for (int j = 0; j < 3; j++) begin
            mosi = j[0]; sck = 1'b1; waitc(H);
            mosi = ~j[0]; sck = 1'b0; waitc(H);
        end
        if (end_high) begin sck = 1'b1; waitc(H); end
        chk(!miso_oe && hold_active, "R8", "held during junk clocks", int'(miso_oe), 0);
    endtask

    // kind: 0 hold while sck low, 1 hold requested while sck high, 2 deselect during hold
    task automatic run_frame(input int mode, input int nbits, input int hold_bit, input int kind);
        int eff;
        eff = (kind == 2 && hold_bit >= 0) ? hold_bit : nbits;
        load_cnt = 0;
        sck = (mode == 3);
        waitc(4);
        for (int k = 0; k < eff / 8; k++) rxq.push_back({mopat(k), 16'(k)});
        fq.push_back((eff % 8) == 0);
        csn = 1'b0;
        waitc(2 * H);
        for (int b = 0; b < nbits; b++) begin
            if (b == hold_bit) begin
                if (kind == 1) begin
                    holdn = 1'b0; waitc(6);
                    chk(!hold_active, "R7", "hold deferred while sck high", int'(hold_active), 0);
                    sck = 1'b0; waitc(6);
                    chk(hold_active, "R7", "hold after sck low", int'(hold_active), 1);
                    junk_pulses(1'b1);
                    holdn = 1'b1; waitc(6);
                    chk(hold_active, "R7", "release deferred while sck high", int'(hold_active), 1);
                    sck = 1'b0; waitc(6);
                    chk(!hold_active && miso_oe, "R7", "released after sck low", int'(hold_active), 0);
                end else begin
                    sck = 1'b0; waitc(H);
                    holdn = 1'b0; waitc(6);
                    chk(hold_active, "R7", "hold while sck low", int'(hold_active), 1);
                    chk(!miso_oe, "R6", "oe off in hold", int'(miso_oe), 0);
                    junk_pulses(1'b0);
                    if (kind == 2) begin
                        csn = 1'b1; waitc(8);
                        chk(!hold_active && !miso_oe, "R9", "deselect clears hold", int'(hold_active), 0);
                        break;
                    end
                    holdn = 1'b1; waitc(6);
                    chk(!hold_active && miso_oe, "R7", "hold released", int'(hold_active), 0);
                end
            end
            sck = 1'b0;
            mosi = mopat(b / 8)[7 - (b % 8)];
            waitc(H);
            chk(miso_oe && (miso == txpat(b / 8)[7 - (b % 8)]), "R4", "miso bit",
                int'(miso), int'(txpat(b / 8)[7 - (b % 8)]));
            sck = 1'b1;
            waitc(H);
        end
        if (!(kind == 2 && hold_bit >= 0)) begin
            if (mode == 0) begin sck = 1'b0; waitc(H); end
            csn = 1'b1;
            waitc(8);
        end
        chk(!miso_oe, "R6", "oe off when deselected", int'(miso_oe), 0);
        chk(rxq.size() == 0, "R2", "all bytes reported", rxq.size(), 0);
        chk(fq.size() == 0, "R5", "frame end reported", fq.size(), 0);
    endtask

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(3);
        chk(!miso_oe && !rx_valid && !hold_active && !frame_end, "R6", "reset state", int'(miso_oe), 0);

        run_frame(0, 24, -1, 0);   // R1 R2 R4 R5 idle-low whole bytes
        run_frame(3, 32, -1, 0);   // R3 idle-high whole bytes
        run_frame(0, 13, -1, 0);   // R5 partial byte
        run_frame(3, 5, -1, 0);    // R5 short partial, idle high
        run_frame(3, 24, 10, 0);   // R7 R8 hold while sck low
        run_frame(0, 24, 12, 1);   // R7 deferred entry and exit
        run_frame(0, 24, 8, 2);    // R9 deselect during hold

        // R9 lock-out: select while hold still low
        sck = 1'b0; waitc(4);
        csn = 1'b0; waitc(2 * H);
        for (int b = 0; b < 8; b++) begin
            mosi = b[0]; waitc(H);
            chk(!miso_oe, "R9", "no output after locked select", int'(miso_oe), 0);
            sck = 1'b1; waitc(H); sck = 1'b0;
        end
        waitc(H);
        csn = 1'b1; waitc(4);
        holdn = 1'b1; waitc(8);
        chk(rxq.size() == 0 && fq.size() == 0, "R9", "nothing queued", rxq.size(), 0);

        run_frame(3, 16, -1, 0);   // R9 recovery after hold released
        finish_up();
    end
endmodule